// File: doc/BRIEF.md
# 8-bit ALU with Register-Pair Carry

This block is the combinational execute stage of an 8-bit accumulator processor. Each cycle it takes the accumulator, one file-register operand, an 8-bit literal, the file-register index, an operation code and the current carry flag. It returns the result byte, where that byte goes (accumulator or file register), whether it is written at all, and the new carry, digit-carry and zero flags. Each flag comes with its own update enable. Operand fetch and register-file writeback are done by the surrounding pipeline.

The second operand is either the file register or the literal. Literal forms always write the accumulator. A register form writes the file register when the direction input is set and the accumulator otherwise.

Five file-register indices (5, 7, 9, 13 and 17) are pair targets. A file-destined add, add-with-carry, subtract, subtract-with-borrow, increment or decrement aimed at one of them treats register index−1 as a high byte. The operation then runs on the 16-bit value and returns a second result byte for that high register. The flags are still taken from the 8-bit operation.

There is no state and no clock, so the block has no states or transitions. The enumerated type names the operations instead.

Top module: `alu8_exec`

## Requirements
- R1: ADD (code 0) returns B+A and ADDC (code 1) returns B+A+carry_i, where B is the selected operand and A is the accumulator. C is the carry out of bit 7 and DC is the carry out of bit 3. C, DC and Z are all updated, with Z set when the result byte is 0.
- R2: SUB (code 2) returns B−A and SUBB (code 3) returns B−A−(1−carry_i). C is 1 when no borrow leaves bit 7 and DC is 1 when no borrow leaves bit 3. C, DC and Z are updated.
- R3: A pair operation needs four things: dir_freg_i=1, use_lit_i=0, reg_idx_i in {5,7,9,13,17}, and an op of ADD, ADDC, SUB, SUBB, INC (8) or DEC (9). It then runs on the 16-bit value {pair_hi_i, freg_i}. result_o is the low byte, result_hi_o is the high byte and hi_we_o=1. Z tests the low byte only.
- R4: In pair operations C and DC equal the values the same 8-bit operation gives on freg_i alone.
- R5: At any other index, and in any other case, hi_we_o=0 and the arithmetic wraps at 8 bits.
- R6: AND (4), OR (5), XOR (6) and COM (7, bitwise complement of B) update only Z.
- R7: INC returns B+1 and DEC returns B−1, and both update only Z.
- R8: RLC (10) returns {B[6:0],carry_i} with C=B[7]. RRC (11) returns {carry_i,B[7:1]} with C=B[0]. Neither updates Z or DC.
- R9: SWAP (12) returns {B[3:0],B[7:4]} and updates no flag.
- R10: CMP (13) sets C, DC and Z exactly as SUB would and writes no result (wr_en_o=0).
- R11: With use_lit_i=1, B is lit_i and the destination is the accumulator. Subtracting with a literal gives lit_i−A.
- R12: dest_freg_o equals dir_freg_i AND NOT use_lit_i. wr_en_o is 1 for codes 0–12 and 0 for codes 13–15. Codes 14 and 15 update no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator value |
| freg_i | input | 8 | Addressed file register |
| pair_hi_i | input | 8 | File register at reg_idx_i−1 |
| lit_i | input | 8 | Instruction literal |
| reg_idx_i | input | REG_IDX_W | File-register index |
| op_i | input | 4 | Operation code (see R1–R12) |
| dir_freg_i | input | 1 | 1: result to file register |
| use_lit_i | input | 1 | 1: literal is operand B |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result byte (low byte in pair mode) |
| result_hi_o | output | 8 | High byte for register reg_idx_i−1 |
| hi_we_o | output | 1 | High byte write enable |
| dest_freg_o | output | 1 | 1: file register, 0: accumulator |
| wr_en_o | output | 1 | Result write enable |
| c_we_o | output | 1 | Carry update enable |
| c_o | output | 1 | New carry |
| dc_we_o | output | 1 | Digit-carry update enable |
| dc_o | output | 1 | New digit-carry |
| z_we_o | output | 1 | Zero update enable |
| z_o | output | 1 | New zero flag |

## Verification
Every output is a function of the present inputs, so each result is due in the same cycle its operands are applied, with no register in the path. The bench changes inputs just after a rising edge and samples on the following falling edge. It compares every output against a behavioural integer model that evaluates the requirement formulas, and it skips flag values whose enable the model expects to be low. Directed vectors cover the carry, borrow, nibble and 16-bit wrap corners at both pair and non-pair indices. A deterministic pseudo-random sweep then covers all sixteen codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBB = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_COM  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_RLC  = 4'd10,
        OP_RRC  = 4'd11,
        OP_SWAP = 4'd12,
        OP_CMP  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    localparam int PAIR_CNT = 5;

    function automatic int pair_index(input int n);
        case (n)
            0:       return 5;
            1:       return 7;
            2:       return 9;
            3:       return 13;
            default: return 17;
        endcase
    endfunction
endpackage

// File: rtl/alu8_pair_match.sv
module alu8_pair_match
    import alu8_pkg::*;
#(
    parameter int REG_IDX_W = 9
) (
    input  logic [REG_IDX_W-1:0] idx_i,
    output logic                 hit_o
);
    logic [PAIR_CNT-1:0] slot_hit;

    for (genvar g = 0; g < PAIR_CNT; g++) begin : g_slot
        assign slot_hit[g] = (idx_i == REG_IDX_W'(pair_index(g)));
    end

    assign hit_o = |slot_hit;
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] hi_i,
    input  logic         sub_i,
    input  logic         ci_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o,
    output logic         c_o,
    output logic         dc_o
);
    localparam int HALF = W / 2;

    logic [W-1:0]    y_eff;
    logic [W:0]      sum_lo;
    logic [HALF:0]   sum_nib;
    logic [W-1:0]    hi_ext;

    always_comb begin
        y_eff   = sub_i ? ~y_i : y_i;
        hi_ext  = sub_i ? {W{1'b1}} : '0;
        sum_lo  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, ci_i};
        sum_nib = {1'b0, x_i[HALF-1:0]} + {1'b0, y_eff[HALF-1:0]} + {{HALF{1'b0}}, ci_i};
        lo_o    = sum_lo[W-1:0];
        c_o     = sum_lo[W];
        dc_o    = sum_nib[HALF];
        hi_o    = hi_i + hi_ext + {{(W-1){1'b0}}, sum_lo[W]};
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e    op_i,
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic       carry_i,
    output logic [7:0] res_o,
    output logic       c_o
);
    always_comb begin
        res_o = b_i;
        c_o   = carry_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  res_o = ~b_i;
            OP_RLC:  begin res_o = {b_i[6:0], carry_i}; c_o = b_i[7]; end
            OP_RRC:  begin res_o = {carry_i, b_i[7:1]}; c_o = b_i[0]; end
            OP_SWAP: res_o = {b_i[3:0], b_i[7:4]};
            default: res_o = b_i;
        endcase
    end
endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
    import alu8_pkg::*;
#(
    parameter int REG_IDX_W = 9
) (
    input  logic [7:0]           acc_i,
    input  logic [7:0]           freg_i,
    input  logic [7:0]           pair_hi_i,
    input  logic [7:0]           lit_i,
    input  logic [REG_IDX_W-1:0] reg_idx_i,
    input  logic [3:0]           op_i,
    input  logic                 dir_freg_i,
    input  logic                 use_lit_i,
    input  logic                 carry_i,
    output logic [7:0]           result_o,
    output logic [7:0]           result_hi_o,
    output logic                 hi_we_o,
    output logic                 dest_freg_o,
    output logic                 wr_en_o,
    output logic                 c_we_o,
    output logic                 c_o,
    output logic                 dc_we_o,
    output logic                 dc_o,
    output logic                 z_we_o,
    output logic                 z_o
);
    alu_op_e    op;
    logic [7:0] opnd_b;
    logic       idx_pair;
    logic       pair_op;
    logic       pair_hit;
    logic [7:0] add_y;
    logic       add_sub;
    logic       add_ci;
    logic [7:0] add_lo;
    logic [7:0] add_hi;
    logic       add_c;
    logic       add_dc;
    logic [7:0] bit_res;
    logic       bit_c;

    assign op     = alu_op_e'(op_i);
    assign opnd_b = use_lit_i ? lit_i : freg_i;

    alu8_pair_match #(.REG_IDX_W(REG_IDX_W)) u_match (
        .idx_i (reg_idx_i),
        .hit_o (idx_pair)
    );

    always_comb begin
        pair_op = 1'b0;
        add_y   = acc_i;
        add_sub = 1'b0;
        add_ci  = 1'b0;
        unique case (op)
            OP_ADD:  pair_op = 1'b1;
            OP_ADDC: begin pair_op = 1'b1; add_ci = carry_i; end
            OP_SUB:  begin pair_op = 1'b1; add_sub = 1'b1; add_ci = 1'b1; end
            OP_SUBB: begin pair_op = 1'b1; add_sub = 1'b1; add_ci = carry_i; end
            OP_CMP:  begin add_sub = 1'b1; add_ci = 1'b1; end
            OP_INC:  begin pair_op = 1'b1; add_y = 8'd1; end
            OP_DEC:  begin pair_op = 1'b1; add_y = 8'd1; add_sub = 1'b1; add_ci = 1'b1; end
            default: add_y = acc_i;
        endcase
    end

    assign pair_hit = pair_op & idx_pair & dir_freg_i & ~use_lit_i;

    alu8_adder #(.W(8)) u_add (
        .x_i   (opnd_b),
        .y_i   (add_y),
        .hi_i  (pair_hi_i),
        .sub_i (add_sub),
        .ci_i  (add_ci),
        .lo_o  (add_lo),
        .hi_o  (add_hi),
        .c_o   (add_c),
        .dc_o  (add_dc)
    );

    alu8_bitops u_bits (
        .op_i    (op),
        .a_i     (acc_i),
        .b_i     (opnd_b),
        .carry_i (carry_i),
        .res_o   (bit_res),
        .c_o     (bit_c)
    );

    always_comb begin
        result_o    = add_lo;
        result_hi_o = pair_hit ? add_hi : pair_hi_i;
        hi_we_o     = pair_hit;
        dest_freg_o = dir_freg_i & ~use_lit_i;
        wr_en_o     = 1'b1;
        c_we_o      = 1'b0;
        c_o         = 1'b0;
        dc_we_o     = 1'b0;
        dc_o        = 1'b0;
        z_we_o      = 1'b0;
        z_o         = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
                c_we_o = 1'b1; c_o = add_c;
                dc_we_o = 1'b1; dc_o = add_dc;
                z_we_o = 1'b1; z_o = (add_lo == 8'd0);
            end
            OP_CMP: begin
                wr_en_o = 1'b0;
                c_we_o = 1'b1; c_o = add_c;
                dc_we_o = 1'b1; dc_o = add_dc;
                z_we_o = 1'b1; z_o = (add_lo == 8'd0);
            end
            OP_INC, OP_DEC: begin
                z_we_o = 1'b1; z_o = (add_lo == 8'd0);
            end
            OP_AND, OP_OR, OP_XOR, OP_COM: begin
                result_o = bit_res;
                z_we_o = 1'b1; z_o = (bit_res == 8'd0);
            end
            OP_RLC, OP_RRC: begin
                result_o = bit_res;
                c_we_o = 1'b1; c_o = bit_c;
            end
            OP_SWAP: result_o = bit_res;
            default: wr_en_o = 1'b0;
        endcase
    end

    always_comb begin
        // R9
        swap_noflag_chk: assert (!(op == OP_SWAP) || !(c_we_o | dc_we_o | z_we_o));
        // R3
        pair_dest_chk: assert (!hi_we_o || (dest_freg_o && wr_en_o && idx_pair));
        // R5
        nonpair_hi_chk: assert (idx_pair || !hi_we_o);
        // R10
        cmp_nowrite_chk: assert (!(op == OP_CMP) || (!wr_en_o && c_we_o && z_we_o));
        // R8
        rlc_carry_chk: assert (!(op == OP_RLC) || (c_o == opnd_b[7] && !z_we_o));
        // R11
        lit_dest_chk: assert (!use_lit_i || (!dest_freg_o && !hi_we_o));
    end
endmodule

// File: tb/alu8_exec_tb.sv
module alu8_exec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc, freg, phi, lit;
    logic [8:0] idx;
    logic [3:0] op;
    logic       dirf, usel, cin;
    logic [7:0] res, res_hi;
    logic       hi_we, destf, wr_en, c_we, c, dc_we, dc, z_we, z;
    int         checks = 0;
    int         failures = 0;
    int         cycles = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    alu8_exec #(.REG_IDX_W(9)) u_dut (
        .acc_i(acc), .freg_i(freg), .pair_hi_i(phi), .lit_i(lit),
        .reg_idx_i(idx), .op_i(op), .dir_freg_i(dirf), .use_lit_i(usel),
        .carry_i(cin), .result_o(res), .result_hi_o(res_hi), .hi_we_o(hi_we),
        .dest_freg_o(destf), .wr_en_o(wr_en), .c_we_o(c_we), .c_o(c),
        .dc_we_o(dc_we), .dc_o(dc), .z_we_o(z_we), .z_o(z)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic bit is_pair_idx(int i);
        return (i == 5) || (i == 7) || (i == 9) || (i == 13) || (i == 17);
    endfunction

    function automatic string tag_of(int o, bit pr, bit ul);
        if (pr) return "R3";
        if (ul && (o == 2 || o == 3)) return "R11";
        case (o)
            0, 1: return "R1";
            2, 3: return "R2";
            4, 5, 6, 7: return "R6";
            8, 9: return "R7";
            10, 11: return "R8";
            12: return "R9";
            13: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic apply(int o, int a, int f, int h, int l, int ix, bit df, bit ul,
                         bit ci, string tag);
        int b, w, er, eh, bw, ci2;
        bit pr, ewr, ecw, edw, ezw, ec, edc, ehw;
        string t;
        @(posedge clk);
        #1;
        acc = 8'(a); freg = 8'(f); phi = 8'(h); lit = 8'(l); idx = 9'(ix);
        op = 4'(o); dirf = df; usel = ul; cin = ci;
        @(negedge clk);
        b = ul ? l : f;
        pr = df && !ul && is_pair_idx(ix) && (o <= 3 || o == 8 || o == 9);
        ewr = (o <= 12); ecw = 0; edw = 0; ezw = 0; ec = 0; edc = 0;
        er = b; eh = h;
        case (o)
            0, 1: begin
                ci2 = (o == 1) ? int'(ci) : 0;
                w = pr ? (h * 256 + f + a + ci2) : (b + a + ci2);
                er = w & 255; eh = (w >> 8) & 255;
                ec = (b + a + ci2) > 255;
                edc = ((b & 15) + (a & 15) + ci2) > 15;
                ecw = 1; edw = 1; ezw = 1;
            end
            2, 3, 13: begin
                bw = (o == 3) ? int'(!ci) : 0;
                w = pr ? (h * 256 + f - a - bw + 65536) : (b - a - bw + 256);
                er = w & 255; eh = (w >> 8) & 255;
                ec = (b - a - bw) >= 0;
                edc = ((b & 15) - (a & 15) - bw) >= 0;
                ecw = 1; edw = 1; ezw = 1;
            end
            4: begin er = a & b; ezw = 1; end
            5: begin er = a | b; ezw = 1; end
            6: begin er = a ^ b; ezw = 1; end
            7: begin er = (~b) & 255; ezw = 1; end
            8, 9: begin
                w = pr ? (h * 256 + f) : b;
                w = (o == 8) ? w + 1 : w - 1 + 65536;
                er = w & 255; eh = (w >> 8) & 255; ezw = 1;
            end
            10: begin er = ((b << 1) | int'(ci)) & 255; ec = b[7]; ecw = 1; end
            11: begin er = (b >> 1) | (int'(ci) << 7); ec = b[0]; ecw = 1; end
            12: er = ((b << 4) | (b >> 4)) & 255;
            default: ;
        endcase
        ehw = pr;
        t = (tag.len() > 0) ? tag : tag_of(o, pr, ul);
        checks = checks + 1;
        if ((ewr && res !== 8'(er)) || (wr_en !== ewr) || (hi_we !== ehw) ||
            (ehw && res_hi !== 8'(eh)) || (destf !== (df && !ul)) ||
            (c_we !== ecw) || (dc_we !== edw) || (z_we !== ezw) ||
            (ecw && c !== ec) || (edw && dc !== edc) ||
            (ezw && z !== (er == 0))) begin
            failures = failures + 1;
            $display("FAIL %s op=%0d actual res=%h hi=%h hw=%b wr=%b d=%b cw=%b c=%b dw=%b dc=%b zw=%b z=%b expected res=%h hi=%h hw=%b wr=%b d=%b cw=%b c=%b dw=%b dc=%b zw=%b z=%b",
                     t, o, res, res_hi, hi_we, wr_en, destf, c_we, c, dc_we, dc, z_we, z,
                     8'(er), 8'(eh), ehw, ewr, (df && !ul), ecw, ec, edw, edc, ezw, (er == 0));
        end
    endtask

    initial begin
        acc = 0; freg = 0; phi = 0; lit = 0; idx = 0; op = 0;
        dirf = 0; usel = 0; cin = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");          // idle inputs: zero result
        apply(0, 8'h01, 8'hFF, 0, 0, 3, 0, 0, 0, "R1");  // carry and zero
        apply(1, 8'h08, 8'h07, 0, 0, 3, 1, 0, 1, "R1");  // digit carry with cin
        apply(2, 8'h10, 8'h05, 0, 0, 3, 0, 0, 0, "R2");  // borrow
        apply(3, 8'h05, 8'h05, 0, 0, 3, 0, 0, 0, "R2");  // borrow-in from cin=0
        apply(3, 8'h05, 8'h05, 0, 0, 3, 0, 0, 1, "R2");
        apply(8, 0, 8'hFF, 8'h00, 0, 5, 1, 0, 0, "R3");  // 00FF+1 -> 0100
        apply(9, 0, 8'h00, 8'h01, 0, 13, 1, 0, 0, "R3"); // 0100-1 -> 00FF
        apply(8, 0, 8'hFF, 8'hFF, 0, 17, 1, 0, 0, "R3"); // FFFF wraps, z on low
        apply(0, 8'h81, 8'hF0, 8'h12, 0, 7, 1, 0, 1, "R4");
        apply(3, 8'h20, 8'h10, 8'h01, 0, 9, 1, 0, 0, "R4");
        apply(8, 0, 8'hFF, 8'h33, 0, 6, 1, 0, 0, "R5");  // non-pair index
        apply(0, 8'h01, 8'hFF, 8'h33, 0, 5, 0, 0, 0, "R5"); // pair index, to acc
        apply(7, 0, 8'hFF, 0, 0, 3, 1, 0, 0, "R6");
        apply(9, 0, 8'h01, 0, 0, 2, 0, 0, 1, "R7");
        apply(10, 0, 8'h80, 0, 0, 2, 1, 0, 1, "R8");
        apply(11, 0, 8'h01, 0, 0, 2, 1, 0, 0, "R8");
        apply(12, 0, 8'h3C, 0, 0, 2, 1, 0, 1, "R9");
        apply(13, 8'h42, 8'h42, 0, 0, 5, 1, 0, 0, "R10");
        apply(2, 8'h03, 8'h00, 0, 8'h10, 5, 1, 1, 0, "R11"); // lit - acc
        apply(14, 8'h11, 8'h22, 0, 0, 5, 1, 0, 1, "R12");
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(int'(lfsr[3:0]), int'(lfsr[11:4]), int'(lfsr[19:12]),
                  int'(lfsr[27:20]), int'(lfsr[31:24]),
                  lfsr[28] ? (4 + 2 * int'(lfsr[2:0])) : int'(lfsr[8:4]),
                  lfsr[29], lfsr[30] & lfsr[5], lfsr[31], "");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule